// File: doc/BRIEF.md
# Programmable User Sync Strobe Generator

This block makes one user-defined video timing strobe from a pixel clock. A pixel counter and a line counter step through each line and each field. The lengths come from the `samples_per_line` and `lines_per_field` inputs, so the block works out no video standard itself. One programmable window covers a range of lines and a second covers a range of pixel positions. A selectable logic operator merges the two windows, and a polarity stage sets the final output level.

Software sets up the block through a small 16-bit register port. The field map is as follows:
- Address 0: first line of the vertical window.
- Address 1: line that ends the vertical window.
- Address 2: first pixel of the horizontal window.
- Address 3: pixel that ends the horizontal window.
- Address 4: control register, with polarity in bit 3, AND select in bit 2, OR select in bit 1 and XOR select in bit 0.

Writes go to shadow registers. The block copies them into its working set only at the end of a frame, so a strobe never changes shape partway through a frame.

For interlaced output a field flag toggles at the end of every field, and a frame ends after the even field. The window line numbers follow the odd field's count, and they apply in the same way to the lines of the even field.

Top module: `usync_gen`

## Requirements
- R1: During and right after reset, `sync_out` is 1, `h_pos` is 0, `v_line` is 1 and `field_even` is 0. Addresses 0 to 3 read 0 and address 4 reads 16'h0008, so polarity is 1 and all operator bits are 0.
- R2: `h_pos` counts 0 to `samples_per_line`-1 and then wraps to 0. `v_line` counts 1 to `lines_per_field` and advances when `h_pos` wraps. Each step takes one clock.
- R3: The vertical window is active on lines where start ≤ `v_line` < stop.
- R4: The vertical window stays inactive when start ≥ stop or when stop > `lines_per_field`.
- R5: The horizontal window is active where hstart ≤ `h_pos` < hstop. It stays inactive when hstart ≥ hstop or when hstop > `samples_per_line`.
- R6: When control bit 2 (AND) is 1, the merged signal is the AND of the two windows, and bits 1 and 0 are ignored.
- R7: When bit 2 is 0 and bit 1 (OR) is 1, the merged signal is the OR of the two windows, and bit 0 is ignored.
- R8: When only bit 0 (XOR) selects, the merged signal is the XOR of the two windows.
- R9: When bits 2 to 0 are all 0, the merged signal follows the vertical window alone.
- R10: When control bit 3 is 1, `sync_out` is the inverse of the merged signal (active low). When bit 3 is 0, `sync_out` equals the merged signal (active high).
- R11: `sync_out` is registered and reflects the counter position of the previous clock. A register write affects the output only from the first pixel of the next frame.
- R12: With `interlaced`=1, `field_even` toggles at each field end, a frame ends only after the even field, and both fields use the same window line numbers. With `interlaced`=0, `field_even` stays 0.
- R13: Reads return the stored fields with unused bits as 0, so a line or pixel register returns bits 14..0 and the control register returns bits 3..0. Writes to addresses 5 to 7 are ignored and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samples_per_line | input | 15 | Pixels per line |
| lines_per_field | input | 15 | Lines per field |
| interlaced | input | 1 | 1 selects two fields per frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the register at `reg_addr` (combinational) |
| h_pos | output | 15 | Current pixel position |
| v_line | output | 15 | Current line in field, counted from 1 |
| field_even | output | 1 | 1 during the even field |
| sync_out | output | 1 | User sync strobe |

## Verification
The counters and the field flag change one clock after the previous position. `sync_out` is due one clock after the counter position that produced it. A register write becomes visible in `sync_out` one clock after the first pixel of the following frame, while a read is due in the same cycle. The bench keeps its own counter and configuration model. At each falling edge it pushes the strobe level due at the next edge into a queue, and one cycle later it pops that level and compares it with `sync_out`. It loads the model's working configuration only on the same frame-end step that the requirements define.

// File: rtl/usync_gen.sv
module usync_gen #(
  parameter int PW = 15,
  parameter int LW = 15,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] samples_per_line,
  input  logic [LW-1:0] lines_per_field,
  input  logic          interlaced,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic [PW-1:0] h_pos,
  output logic [LW-1:0] v_line,
  output logic          field_even,
  output logic          sync_out
);
  localparam int DW = 16;
  localparam logic [3:0] CTL_RST = 4'b1000;

  logic [LW-1:0] sh_vs, sh_ve, a_vs, a_ve;
  logic [PW-1:0] sh_hs, sh_he, a_hs, a_he;
  logic [3:0]    sh_ctl, a_ctl;
  logic          line_end, field_end, frame_end;
  logic          v_win, h_win, merged;
  logic [PW-1:0] last_pix;

  assign last_pix  = samples_per_line - 1'b1;
  assign line_end  = h_pos >= last_pix;
  assign field_end = line_end && (v_line >= lines_per_field);
  assign frame_end = field_end && (!interlaced || field_even);

  assign v_win = (a_vs < a_ve) && (a_ve <= lines_per_field) &&
                 (v_line >= a_vs) && (v_line < a_ve);
  assign h_win = (a_hs < a_he) && (a_he <= samples_per_line) &&
                 (h_pos >= a_hs) && (h_pos < a_he);

  always_comb begin
    if (a_ctl[2])      merged = h_win & v_win;
    else if (a_ctl[1]) merged = h_win | v_win;
    else if (a_ctl[0]) merged = h_win ^ v_win;
    else               merged = v_win;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_vs <= '0; sh_ve <= '0; sh_hs <= '0; sh_he <= '0; sh_ctl <= CTL_RST;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: sh_vs <= reg_wdata[LW-1:0];
        3'd1: sh_ve <= reg_wdata[LW-1:0];
        3'd2: sh_hs <= reg_wdata[PW-1:0];
        3'd3: sh_he <= reg_wdata[PW-1:0];
        3'd4: sh_ctl <= reg_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vs <= '0; a_ve <= '0; a_hs <= '0; a_he <= '0; a_ctl <= CTL_RST;
    end else if (frame_end) begin
      a_vs <= sh_vs; a_ve <= sh_ve; a_hs <= sh_hs; a_he <= sh_he; a_ctl <= sh_ctl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_pos      <= '0;
      v_line     <= LW'(1);
      field_even <= 1'b0;
      sync_out   <= 1'b1;
    end else begin
      h_pos <= line_end ? '0 : h_pos + 1'b1;
      if (field_end) begin
        v_line     <= LW'(1);
        field_even <= interlaced & ~field_even;
      end else if (line_end) begin
        v_line <= v_line + 1'b1;
      end
      sync_out <= a_ctl[3] ? ~merged : merged;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {{(DW-LW){1'b0}}, sh_vs};
      3'd1:    reg_rdata = {{(DW-LW){1'b0}}, sh_ve};
      3'd2:    reg_rdata = {{(DW-PW){1'b0}}, sh_hs};
      3'd3:    reg_rdata = {{(DW-PW){1'b0}}, sh_he};
      3'd4:    reg_rdata = {12'b0, sh_ctl};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module usync_gen_chk #(
  parameter int PW = 15,
  parameter int LW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] samples_per_line,
  input logic [PW-1:0] h_pos,
  input logic [LW-1:0] v_line,
  input logic          field_even,
  input logic          frame_end,
  input logic [3:0]    a_ctl,
  input logic [3:0]    sh_ctl,
  input logic [PW-1:0] a_hs,
  input logic [PW-1:0] a_he,
  input logic          sync_out
);
  logic [PW-1:0] lastp;
  assign lastp = samples_per_line - 1'b1;

  p_pix_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(h_pos) >= $past(lastp)) |-> (h_pos == '0));

  p_field_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_even) |-> (h_pos == '0 && v_line == LW'(1)));

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> (a_ctl == $past(a_ctl)));

  p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_end) |-> (a_ctl == $past(sh_ctl)));

  p_and_hblock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctl[2] && (a_hs >= a_he)) |=> (sync_out == $past(a_ctl[3])));
endmodule

bind usync_gen usync_gen_chk #(.PW(PW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .samples_per_line(samples_per_line),
  .h_pos(h_pos), .v_line(v_line), .field_even(field_even),
  .frame_end(frame_end), .a_ctl(a_ctl), .sh_ctl(sh_ctl),
  .a_hs(a_hs), .a_he(a_he), .sync_out(sync_out)
);

// File: tb/test_usync_gen.sv
module test_usync_gen;
  localparam int SPL = 8;
  localparam int LPF = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [14:0] samples_per_line = 15'(SPL);
  logic [14:0] lines_per_field = 15'(LPF);
  logic        interlaced = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [14:0] h_pos, v_line;
  logic        field_even, sync_out;

  usync_gen i_usync_gen (.*);

  always #5 clk = ~clk;

  int total = 0, failed = 0;
  string cur_tag = "R1";
  bit    eq[$];
  string tq[$];
  logic [14:0] m_sh[4], m_a[4];
  logic [3:0]  m_shc = 4'h8, m_ac = 4'h8;
  int bp = 0, bl = 1;
  bit bf = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_out();
    bit v, h, m;
    v = (m_a[0] < m_a[1]) && (m_a[1] <= LPF) && (bl >= m_a[0]) && (bl < m_a[1]);
    h = (m_a[2] < m_a[3]) && (m_a[3] <= SPL) && (bp >= m_a[2]) && (bp < m_a[3]);
    if (m_ac[2])      m = h & v;
    else if (m_ac[1]) m = h | v;
    else if (m_ac[0]) m = h ^ v;
    else              m = v;
    return m_ac[3] ? ~m : m;
  endfunction

  task automatic model_step();
    bit le, fe, fre;
    eq.push_back(model_out());
    tq.push_back(cur_tag);
    le  = (bp >= SPL - 1);
    fe  = le && (bl >= LPF);
    fre = fe && (!interlaced || bf);
    bp = le ? 0 : bp + 1;
    if (fe) begin bl = 1; bf = interlaced & ~bf; end
    else if (le) bl = bl + 1;
    if (fre) begin
      for (int i = 0; i < 4; i++) m_a[i] = m_sh[i];
      m_ac = m_shc;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_sh[i] = 0; m_a[i] = 0; end
    @(posedge rst_n);
    model_step();
    forever begin
      @(negedge clk);
      chk("R2 h_pos", 32'(h_pos), 32'(bp));
      chk("R2 v_line", 32'(v_line), 32'(bl));
      chk("R12 field_even", 32'(field_even), 32'(bf));
      if (eq.size() > 0) begin
        bit e;
        string t;
        e = eq.pop_front();
        t = tq.pop_front();
        chk({t, " sync_out"}, 32'(sync_out), 32'(e));
      end
      model_step();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a < 4) m_sh[a] = d[14:0];
    else if (a == 4) m_shc = d[3:0];
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, 32'(reg_rdata), 32'(e));
  endtask

  task automatic frames(input int n);
    repeat (n * SPL * LPF * 2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sync_out", 32'(sync_out), 1);
    chk("R1 h_pos", 32'(h_pos), 0);
    chk("R1 v_line", 32'(v_line), 1);
    chk("R1 field", 32'(field_even), 0);
    for (int a = 0; a < 4; a++) rd(3'(a), 16'h0000, "R1 reg");
    rd(3'd4, 16'h0008, "R1 ctl");
    @(negedge clk);
    rst_n = 1;
    frames(1);
    cur_tag = "R3";
    repeat (13) @(negedge clk);
    wr(0, 2); wr(1, 4);
    cur_tag = "R11";
    frames(1);
    cur_tag = "R3";
    frames(1);
    cur_tag = "R4"; wr(0, 4); wr(1, 2); frames(1);
    wr(0, 2); wr(1, 7); frames(1);
    wr(1, 6); frames(1);
    cur_tag = "R6"; wr(2, 2); wr(3, 5); wr(4, 16'h000F); frames(1);
    cur_tag = "R5"; wr(2, 5); wr(3, 3); frames(1);
    wr(2, 1); wr(3, 9); frames(1);
    wr(2, 2); wr(3, 5);
    cur_tag = "R7"; wr(4, 16'h000B); frames(1);
    cur_tag = "R8"; wr(4, 16'h0009); frames(1);
    cur_tag = "R10"; wr(4, 16'h0001); frames(1);
    cur_tag = "R9"; wr(4, 16'h0000); frames(1);
    cur_tag = "R12";
    @(posedge clk); #1 interlaced = 1;
    wr(0, 1); wr(1, 3); wr(4, 16'h0006); frames(3);
    @(posedge clk); #1 interlaced = 0;
    frames(1);
    cur_tag = "R13";
    wr(0, 16'hFFFF); rd(3'd0, 16'h7FFF, "R13 line field");
    wr(4, 16'hFFF4); rd(3'd4, 16'h0004, "R13 ctl field");
    wr(5, 16'h1234); rd(3'd5, 16'h0000, "R13 addr5");
    rd(3'd1, 16'h0003, "R13 untouched");
    rd(3'd2, 16'h0002, "R13 untouched");
    frames(1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule